// File: doc/BRIEF.md
# Configuration Address/Data Port Bridge

This block sits on the host side of a configuration fabric. It exposes two 32-bit I/O ports to the CPU. The first is a selector port, which holds a packed target descriptor. The second is a data window, through which the CPU reads or writes one, two or four bytes of the selected configuration dword.

Each data-window access is decoded into an enable flag, a bus number, a device number, a function number and a dword register index, all taken from the stored selector word. The byte position inside the dword comes from the low two bits of the data-window access offset. The bridge checks the access, then either answers at once (error or disabled) or sends exactly one request on a simple pulse request/response interface. That request carries a byte-enable mask and lane-shifted write data. Read data returned by the target is shifted down to bit 0 before it goes back to the CPU.

Only one configuration request is outstanding at a time. While it is pending the bridge reports busy and ignores host accesses. The target must answer no earlier than the cycle after the request pulse.

Top module: `cfg_port_bridge`

## Requirements
- R1: The selector register resets to zero. A selector write (io_sel=0, io_write=1) stores io_wdata with bits 1:0 forced to zero, whatever io_size and io_offset are. A selector read returns the stored word. Both are acknowledged on the next cycle with io_err low; a selector write returns io_rdata zero.
- R2: An issued request drives cfg_bus from selector bits 23:16, cfg_dev from bits 15:11, cfg_fn from bits 10:8 and cfg_reg from bits 7:2.
- R3: When selector bit 31 is clear, a well-formed data-window access issues no request. It is acknowledged with io_err low and io_rdata all ones; a write is discarded.
- R4: A data-window access is malformed, and is acknowledged with io_err high, io_rdata all ones and no request, in any of these cases: io_size is 3; a 2-byte access is at offset 3; a 4-byte access has a non-zero offset; or the start byte (register index times 4 plus offset) exceeds 252 for 4 bytes, 254 for 2 bytes or 255 for 1 byte. This check takes precedence over the enable check of R3.
- R5: The io_size encoding is 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes. An issued request has cfg_be set on lanes offset to offset+width-1 (lane i covers data bits 8i+7:8i, little-endian), and cfg_wdata equals io_wdata shifted left by 8 times the offset.
- R6: For an issued read, io_rdata equals cfg_rdata shifted right by 8 times the offset, with every byte above the access width zeroed. For an issued write, io_rdata is zero.
- R7: A legal, enabled access produces exactly one single-cycle cfg_req pulse. io_busy is high from that pulse until the cycle in which cfg_rsp is seen. io_ack follows in the next cycle with io_err low.
- R8: A host access presented while io_busy is high is ignored: it changes no state and produces no acknowledgement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_valid | input | 1 | Host access strobe, one cycle |
| io_write | input | 1 | 1 = write, 0 = read |
| io_sel | input | 1 | 0 = selector port, 1 = data window |
| io_size | input | 2 | Access width code (see R5) |
| io_offset | input | 2 | Byte offset within the data window |
| io_wdata | input | 32 | Host write data, aligned to bit 0 |
| io_ack | output | 1 | Access completion pulse |
| io_err | output | 1 | Malformed access, valid with io_ack |
| io_rdata | output | 32 | Read result, valid with io_ack |
| io_busy | output | 1 | Configuration request outstanding |
| cfg_req | output | 1 | Configuration request pulse |
| cfg_we | output | 1 | Request is a write |
| cfg_bus | output | 8 | Target bus number |
| cfg_dev | output | 5 | Target device number |
| cfg_fn | output | 3 | Target function number |
| cfg_reg | output | 6 | Target dword register index |
| cfg_be | output | 4 | Byte-lane enables |
| cfg_wdata | output | 32 | Lane-positioned write data |
| cfg_rsp | input | 1 | Target response pulse |
| cfg_rdata | input | 32 | Target read dword, valid with cfg_rsp |

## Verification
Some rules are checked by the bound assertions on every cycle. A request never goes out while the enable flag is clear. Every byte-enable mask covers exactly 1, 2 or 4 lanes. A request is a single-cycle pulse made only while busy. An error acknowledgement always carries all-ones data. No acknowledgement appears while a request waits for its response.

Other behaviour needs the bench's scenarios to show. These are the exact field decode, the lane position of write data and byte enables, the down-shift and masking of read data, the boundary offsets 252, 254 and 255, the precedence of the error check over the disable rule, and the discarding of accesses made while busy.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;
  localparam int DATA_W      = 32;
  localparam int LANES       = DATA_W / 8;
  localparam int OFF_W       = $clog2(LANES);
  localparam int BUS_W       = 8;
  localparam int DEV_W       = 5;
  localparam int FN_W        = 3;
  localparam int REG_W       = 6;
  localparam int EN_BIT      = 31;
  localparam int BUS_LSB     = 16;
  localparam int DEV_LSB     = 11;
  localparam int FN_LSB      = 8;
  localparam int REG_LSB     = 2;
  localparam int SPACE_BYTES = 1 << (REG_W + REG_LSB);
  localparam int END_W       = REG_W + REG_LSB + 2;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } size_e;

  typedef enum logic {ST_IDLE, ST_WAIT} state_e;

  typedef struct packed {
    logic              write;
    logic [1:0]        size;
    logic [OFF_W-1:0]  off;
    logic [DATA_W-1:0] wdata;
  } op_t;

  // number of bytes moved for a size code, zero for the unused code
  function automatic logic [3:0] size_bytes(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: return 4'd1;
      SZ_HALF: return 4'd2;
      SZ_WORD: return 4'd4;
      default: return 4'd0;
    endcase
  endfunction

  // lanes touched by an access of width sz starting at byte off
  function automatic logic [LANES-1:0] lane_mask(input logic [1:0] sz,
                                                 input logic [OFF_W-1:0] off);
    logic [LANES-1:0] base;
    case (sz)
      SZ_BYTE: base = LANES'(1);
      SZ_HALF: base = LANES'(3);
      SZ_WORD: base = '1;
      default: base = '0;
    endcase
    return base << off;
  endfunction

  // well-formed: known size, stays inside one dword, ends inside the space
  function automatic logic access_ok(input logic [1:0] sz,
                                     input logic [OFF_W-1:0] off,
                                     input logic [REG_W-1:0] rg);
    logic [3:0]       n;
    logic [END_W-1:0] end_byte;
    n        = size_bytes(sz);
    end_byte = {2'b00, rg, 2'b00} + END_W'(off) + END_W'(n);
    return (n != 4'd0) && ((4'(off) + n) <= 4'(LANES))
           && (end_byte <= END_W'(SPACE_BYTES));
  endfunction
endpackage

// File: rtl/cfgb_addr_reg.sv
module cfgb_addr_reg
  import cfgb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      q <= '0;
    else if (wr_en)
      q <= {wdata[DATA_W-1:REG_LSB], {REG_LSB{1'b0}}};
  end
endmodule

// File: rtl/cfgb_lanes.sv
module cfgb_lanes
  import cfgb_pkg::*;
(
  input  logic [1:0]        size,
  input  logic [OFF_W-1:0]  off,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] raw_rdata,
  output logic [LANES-1:0]  be,
  output logic [DATA_W-1:0] lane_wdata,
  output logic [DATA_W-1:0] aligned_rdata
);
  logic [LANES-1:0]  keep_lanes;
  logic [DATA_W-1:0] keep_bits;
  logic [DATA_W-1:0] shifted;

  assign be         = lane_mask(size, off);
  assign keep_lanes = lane_mask(size, '0);
  assign lane_wdata = wdata << {off, 3'b000};
  assign shifted    = raw_rdata >> {off, 3'b000};

  for (genvar i = 0; i < LANES; i++) begin : g_keep
    assign keep_bits[8*i +: 8] = {8{keep_lanes[i]}};
  end

  assign aligned_rdata = shifted & keep_bits;
endmodule

// File: rtl/cfgb_ctrl.sv
module cfgb_ctrl
  import cfgb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_valid,
  input  logic              io_write,
  input  logic              io_sel,
  input  logic [1:0]        io_size,
  input  logic [OFF_W-1:0]  io_offset,
  input  logic [DATA_W-1:0] io_wdata,
  input  logic [DATA_W-1:0] addr_q,
  input  logic              cfg_rsp,
  input  logic [DATA_W-1:0] rd_aligned,
  output logic              addr_wr,
  output op_t               op_q,
  output logic              cfg_req,
  output logic              io_ack,
  output logic              io_err,
  output logic [DATA_W-1:0] io_rdata,
  output logic              io_busy
);
  state_e state;
  logic   accept;
  logic   legal;
  logic   enabled;

  assign accept  = io_valid && (state == ST_IDLE);
  assign legal   = access_ok(io_size, io_offset, addr_q[REG_LSB +: REG_W]);
  assign enabled = addr_q[EN_BIT];
  assign addr_wr = accept && !io_sel && io_write;
  assign io_busy = (state == ST_WAIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cfg_req  <= 1'b0;
      io_ack   <= 1'b0;
      io_err   <= 1'b0;
      io_rdata <= '0;
      op_q     <= '0;
    end else begin
      cfg_req <= 1'b0;
      io_ack  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            op_q.write <= io_write;
            op_q.size  <= io_size;
            op_q.off   <= io_offset;
            op_q.wdata <= io_wdata;
            if (!io_sel) begin
              io_ack   <= 1'b1;
              io_err   <= 1'b0;
              io_rdata <= io_write ? '0 : addr_q;
            end else if (!legal) begin
              io_ack   <= 1'b1;
              io_err   <= 1'b1;
              io_rdata <= '1;
            end else if (!enabled) begin
              io_ack   <= 1'b1;
              io_err   <= 1'b0;
              io_rdata <= '1;
            end else begin
              cfg_req <= 1'b1;
              state   <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (cfg_rsp) begin
            io_ack   <= 1'b1;
            io_err   <= 1'b0;
            io_rdata <= op_q.write ? '0 : rd_aligned;
            state    <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfg_port_bridge.sv
module cfg_port_bridge
  import cfgb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_valid,
  input  logic              io_write,
  input  logic              io_sel,
  input  logic [1:0]        io_size,
  input  logic [1:0]        io_offset,
  input  logic [31:0]       io_wdata,
  output logic              io_ack,
  output logic              io_err,
  output logic [31:0]       io_rdata,
  output logic              io_busy,
  output logic              cfg_req,
  output logic              cfg_we,
  output logic [7:0]        cfg_bus,
  output logic [4:0]        cfg_dev,
  output logic [2:0]        cfg_fn,
  output logic [5:0]        cfg_reg,
  output logic [3:0]        cfg_be,
  output logic [31:0]       cfg_wdata,
  input  logic              cfg_rsp,
  input  logic [31:0]       cfg_rdata
);
  logic [DATA_W-1:0] addr_q;
  logic              addr_wr;
  logic              addr_en;
  logic [DATA_W-1:0] rd_aligned;
  op_t               op_q;

  assign addr_en = addr_q[EN_BIT];

  cfgb_addr_reg i_addr (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (addr_wr),
    .wdata (io_wdata),
    .q     (addr_q)
  );

  cfgb_ctrl i_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .io_valid   (io_valid),
    .io_write   (io_write),
    .io_sel     (io_sel),
    .io_size    (io_size),
    .io_offset  (io_offset),
    .io_wdata   (io_wdata),
    .addr_q     (addr_q),
    .cfg_rsp    (cfg_rsp),
    .rd_aligned (rd_aligned),
    .addr_wr    (addr_wr),
    .op_q       (op_q),
    .cfg_req    (cfg_req),
    .io_ack     (io_ack),
    .io_err     (io_err),
    .io_rdata   (io_rdata),
    .io_busy    (io_busy)
  );

  cfgb_lanes i_lanes (
    .size          (op_q.size),
    .off           (op_q.off),
    .wdata         (op_q.wdata),
    .raw_rdata     (cfg_rdata),
    .be            (cfg_be),
    .lane_wdata    (cfg_wdata),
    .aligned_rdata (rd_aligned)
  );

  assign cfg_we  = op_q.write;
  assign cfg_bus = addr_q[BUS_LSB +: BUS_W];
  assign cfg_dev = addr_q[DEV_LSB +: DEV_W];
  assign cfg_fn  = addr_q[FN_LSB +: FN_W];
  assign cfg_reg = addr_q[REG_LSB +: REG_W];
endmodule

// File: rtl/cfgb_checker.sv
module cfgb_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        io_busy,
  input logic        io_ack,
  input logic        io_err,
  input logic [31:0] io_rdata,
  input logic        cfg_req,
  input logic        cfg_rsp,
  input logic [3:0]  cfg_be,
  input logic        addr_en
);
  AST_REQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> addr_en); // R3

  AST_BE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> ($countones(cfg_be) == 1 || $countones(cfg_be) == 2 ||
                 $countones(cfg_be) == 4)); // R5

  AST_REQ_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |=> !cfg_req); // R7

  AST_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> io_busy); // R7

  AST_NO_ACK_BEFORE_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    (io_busy && !cfg_rsp) |=> !io_ack); // R8

  AST_ERR_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (io_ack && io_err) |-> (io_rdata == 32'hFFFF_FFFF)); // R4
endmodule

bind cfg_port_bridge cfgb_checker i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .io_busy  (io_busy),
  .io_ack   (io_ack),
  .io_err   (io_err),
  .io_rdata (io_rdata),
  .cfg_req  (cfg_req),
  .cfg_rsp  (cfg_rsp),
  .cfg_be   (cfg_be),
  .addr_en  (addr_en)
);

// File: tb/test_cfg_port_bridge.sv
module test_cfg_port_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_valid = 1'b0, io_write = 1'b0, io_sel = 1'b0;
  logic [1:0]  io_size = 2'd0, io_offset = 2'd0;
  logic [31:0] io_wdata = '0;
  logic        io_ack, io_err, io_busy;
  logic [31:0] io_rdata;
  logic        cfg_req, cfg_we;
  logic [7:0]  cfg_bus;
  logic [4:0]  cfg_dev;
  logic [2:0]  cfg_fn;
  logic [5:0]  cfg_reg;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_wdata;
  logic        cfg_rsp = 1'b0;
  logic [31:0] cfg_rdata = '0;

  int nchk = 0;
  int nfail = 0;
  int req_cnt = 0;
  int pend = 0;
  logic [7:0]  cap_bus;
  logic [4:0]  cap_dev;
  logic [2:0]  cap_fn;
  logic [5:0]  cap_reg;
  logic [3:0]  cap_be;
  logic [31:0] cap_wdata;
  logic        cap_we;

  always #2 clk = ~clk; // 250 MHz

  cfg_port_bridge i_cfg_port_bridge (
    .clk(clk), .rst_n(rst_n), .io_valid(io_valid), .io_write(io_write),
    .io_sel(io_sel), .io_size(io_size), .io_offset(io_offset),
    .io_wdata(io_wdata), .io_ack(io_ack), .io_err(io_err),
    .io_rdata(io_rdata), .io_busy(io_busy), .cfg_req(cfg_req),
    .cfg_we(cfg_we), .cfg_bus(cfg_bus), .cfg_dev(cfg_dev), .cfg_fn(cfg_fn),
    .cfg_reg(cfg_reg), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_rsp(cfg_rsp), .cfg_rdata(cfg_rdata)
  );

  function automatic logic [31:0] model_word(input logic [7:0] b,
      input logic [4:0] d, input logic [2:0] f, input logic [5:0] r);
    return {b, d, f, 2'b01, r, 8'h5A} ^ 32'h0F0F_3C3C;
  endfunction

  // target model: answers two cycles after the request pulse
  always @(negedge clk) begin
    cfg_rsp = 1'b0;
    if (cfg_req) begin
      req_cnt++;
      cap_bus = cfg_bus; cap_dev = cfg_dev; cap_fn = cfg_fn; cap_reg = cfg_reg;
      cap_be = cfg_be; cap_wdata = cfg_wdata; cap_we = cfg_we;
      pend = 2;
    end else if (pend > 0) begin
      pend--;
      if (pend == 0) begin
        cfg_rsp   = 1'b1;
        cfg_rdata = model_word(cap_bus, cap_dev, cap_fn, cap_reg);
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic sel, input logic wr, input logic [1:0] sz,
                        input logic [1:0] off, input logic [31:0] wd,
                        output logic [31:0] rd, output logic er, output int nreq);
    int r0;
    int t;
    r0 = req_cnt;
    @(negedge clk);
    io_valid = 1'b1; io_sel = sel; io_write = wr; io_size = sz;
    io_offset = off; io_wdata = wd;
    @(negedge clk);
    io_valid = 1'b0;
    t = 0;
    while (!io_ack && t < 50) begin
      @(negedge clk);
      t++;
    end
    if (t == 50) check("R7 ack timeout", 32'd0, 32'd1);
    rd = io_rdata;
    er = io_err;
    nreq = req_cnt - r0;
  endtask

  // {en, wr, size, off, reg, bus, dev, fn}
  localparam int NVEC = 14;
  localparam logic [27:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 2'd2, 2'd0, 6'd0,  8'h00, 5'd0,  3'd0},
    {1'b1, 1'b0, 2'd0, 2'd3, 6'd5,  8'h03, 5'd17, 3'd5},
    {1'b1, 1'b0, 2'd1, 2'd2, 6'd63, 8'hFF, 5'd31, 3'd7},
    {1'b1, 1'b1, 2'd2, 2'd0, 6'd63, 8'h12, 5'd9,  3'd1},
    {1'b1, 1'b1, 2'd0, 2'd1, 6'd10, 8'h80, 5'd2,  3'd3},
    {1'b1, 1'b1, 2'd1, 2'd0, 6'd1,  8'h41, 5'd20, 3'd6},
    {1'b1, 1'b0, 2'd1, 2'd3, 6'd7,  8'h22, 5'd4,  3'd2},
    {1'b1, 1'b0, 2'd2, 2'd1, 6'd8,  8'h23, 5'd5,  3'd0},
    {1'b1, 1'b1, 2'd3, 2'd0, 6'd9,  8'h24, 5'd6,  3'd4},
    {1'b0, 1'b0, 2'd2, 2'd0, 6'd2,  8'h31, 5'd7,  3'd1},
    {1'b0, 1'b1, 2'd1, 2'd0, 6'd3,  8'h32, 5'd8,  3'd2},
    {1'b1, 1'b0, 2'd0, 2'd3, 6'd63, 8'h99, 5'd11, 3'd3},
    {1'b0, 1'b0, 2'd2, 2'd2, 6'd4,  8'h55, 5'd12, 3'd5},
    {1'b1, 1'b0, 2'd1, 2'd1, 6'd20, 8'hA7, 5'd29, 3'd6}
  };

  initial begin
    logic [31:0] rd;
    logic        er;
    int          nr;
    // reset state
    repeat (3) @(negedge clk);
    check("R1 reset ack", {31'd0, io_ack}, 32'd0);
    check("R7 reset req", {31'd0, cfg_req}, 32'd0);
    check("R7 reset busy", {31'd0, io_busy}, 32'd0);
    rst_n = 1'b1;
    access(1'b0, 1'b0, 2'd2, 2'd0, 32'd0, rd, er, nr);
    check("R1 reset selector", rd, 32'd0);

    // selector write ignores size/offset, clears bits 1:0
    access(1'b0, 1'b1, 2'd0, 2'd3, 32'hFFFF_FFFF, rd, er, nr);
    check("R1 selector write err", {31'd0, er}, 32'd0);
    check("R1 selector write rdata", rd, 32'd0);
    access(1'b0, 1'b0, 2'd1, 2'd1, 32'd0, rd, er, nr);
    check("R1 selector readback", rd, 32'hFFFF_FFFC);

    for (int i = 0; i < NVEC; i++) begin
      logic [27:0] v;
      logic en, wr;
      logic [1:0] sz, off;
      logic [5:0] rg;
      logic [7:0] bs;
      logic [4:0] dv;
      logic [2:0] fn;
      logic [31:0] aw, wd, exp_rd, word;
      logic [3:0] exp_be;
      int n;
      logic legal, issue;
      v = VEC[i];
      {en, wr, sz, off, rg, bs, dv, fn} = v;
      aw = {en, 7'h00, bs, dv, fn, rg, 2'b11};
      access(1'b0, 1'b1, 2'd2, 2'd0, aw, rd, er, nr);
      wd = 32'h8E3D_51A7 + i * 32'h0101_0013;
      access(1'b1, wr, sz, off, wd, rd, er, nr);
      n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : (sz == 2'd2) ? 4 : 0;
      legal = (n != 0) && (int'(off) + n <= 4) && (int'(rg) * 4 + int'(off) + n <= 256);
      issue = legal && en;
      check("R4 err flag", {31'd0, er}, {31'd0, !legal});
      check("R3 R7 request count", nr, issue ? 1 : 0);
      if (!issue) begin
        check("R3 R4 no-issue rdata", rd, 32'hFFFF_FFFF);
      end else begin
        check("R2 bus", {24'd0, cap_bus}, {24'd0, bs});
        check("R2 dev", {27'd0, cap_dev}, {27'd0, dv});
        check("R2 fn", {29'd0, cap_fn}, {29'd0, fn});
        check("R2 reg", {26'd0, cap_reg}, {26'd0, rg});
        for (int k = 0; k < 4; k++) exp_be[k] = (k >= int'(off)) && (k < int'(off) + n);
        check("R5 byte enables", {28'd0, cap_be}, {28'd0, exp_be});
        check("R5 write flag", {31'd0, cap_we}, {31'd0, wr});
        if (wr) begin
          check("R5 lane wdata", cap_wdata, wd << (8 * off));
          check("R6 write rdata", rd, 32'd0);
        end else begin
          word = model_word(bs, dv, fn, rg);
          exp_rd = '0;
          for (int k = 0; k < n; k++) exp_rd[8*k +: 8] = word[8*(k + int'(off)) +: 8];
          check("R6 read alignment", rd, exp_rd);
        end
      end
    end

    // R8: access during busy is dropped
    access(1'b0, 1'b1, 2'd2, 2'd0, 32'h8012_3404, rd, er, nr);
    begin
      int r0;
      int t;
      r0 = req_cnt;
      @(negedge clk);
      io_valid = 1'b1; io_sel = 1'b1; io_write = 1'b0; io_size = 2'd2; io_offset = 2'd0;
      @(negedge clk);
      check("R7 busy after request", {31'd0, io_busy}, 32'd1);
      io_sel = 1'b0; io_write = 1'b1; io_wdata = 32'h0000_0000;
      @(negedge clk);
      io_valid = 1'b0;
      t = 0;
      while (!io_ack && t < 50) begin
        @(negedge clk);
        t++;
      end
      check("R7 one request", req_cnt - r0, 32'd1);
      @(negedge clk);
      check("R8 no extra ack", {31'd0, io_ack}, 32'd0);
    end
    access(1'b0, 1'b0, 2'd2, 2'd0, 32'd0, rd, er, nr);
    check("R8 selector unchanged", rd, 32'h8012_3404);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog R7 actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule